// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes a processor from an accepted interrupt request to the moment its handler address sits in the program counter. It decides when an entry may begin. That is at an instruction boundary, or at once during a block-move, block-store or repeated multiply-accumulate instruction, which are suspended. It then runs a fixed twenty-cycle bus schedule with these steps:

- two acknowledge reads that return the interrupt number and request level;
- a copy of the flag register into a hidden temporary;
- clearing of the mode flags;
- four byte writes to the stack;
- raising of the priority level;
- three vector-byte reads.

In the last cycle the new program counter and the stack pointer (lowered by four) are committed, and a done pulse is given.

The flag register is 12 bits wide. The stack-select flag is bit 7, the interrupt-enable flag is bit 6, the single-step flag is bit 5, and the priority level field is bits 10:8. The entry vector of interrupt number n lies at VEC_BASE + 4n. A software interrupt instruction starts an entry directly through `swi_req`. It has no acknowledge reads and keeps the current priority level.

States, in order, with one cycle each unless noted:

- ST_IDLE: waits for a start.
- ST_ACK_NUM (cycle 0) and ST_ACK_LVL (cycle 1): the acknowledge reads.
- ST_SAVE (cycle 2): the flag copy and mode-flag clearing.
- ST_HOLD_A (cycles 3 to 5): no bus activity.
- ST_PUSH_F0 (cycle 6) and ST_PUSH_F1 (cycle 7): the two flag bytes.
- ST_HOLD_B (cycles 8 and 9): no bus activity.
- ST_PUSH_P0 (cycle 10) and ST_PUSH_P1 (cycle 11): the two program-counter bytes.
- ST_SET_IPL (cycle 12): the priority level is raised.
- ST_VEC0, ST_GAP0, ST_VEC1, ST_GAP1, ST_VEC2, ST_GAP2 (cycles 13 to 18): vector reads alternating with idle cycles.
- ST_LOAD (cycle 19): the commit.

Transitions:

- ST_IDLE goes to ST_ACK_NUM on a start.
- Each hold state leaves when its cycle count is used up.
- Every other state goes to the next state in the list.
- ST_LOAD returns to ST_IDLE.

Top module: `irq_entry_seq`

## Requirements
- R1: In the idle state, an entry starts on the next clock edge when `swi_req` is 1, or when `irq_req` is 1 together with `at_boundary` or `str_active`. With `irq_req` and neither of the other two, nothing starts. `suspend` is 1, combinationally, exactly when the block is idle, `swi_req` is 0, `irq_req` is 1, `str_active` is 1 and `at_boundary` is 0.
- R2: For a hardware entry, cycles 0 and 1 are reads at address 00000h. The interrupt number is taken from bits 5:0 of the first read byte, and the request level from bits 2:0 of the second.
- R3: A software entry has priority over a simultaneous hardware request. Cycles 0 and 1 drive no strobe. The number is `swi_num`, and the level is the incoming flag bits 10:8.
- R4: At the edge that ends cycle 2, the flags are copied to the temporary, and bits 6 and 5 of `flg_out` are cleared. Bit 7 is also cleared, except in the case of R5.
- R5: On a software entry with a number from 32 to 63, bit 7 of `flg_out` keeps its value.
- R6: The stack writes are made in this order: cycle 6 to SP-2 with temp[7:0], cycle 7 to SP-1 with {PC[19:16], temp[11:8]}, cycle 10 to SP-4 with PC[7:0], and cycle 11 to SP-3 with PC[15:8]. Here SP and PC are the values captured at the start, and the addresses are 16-bit wrapped and zero-extended to 20 bits.
- R7: At the edge that ends cycle 12, `flg_out` bits 10:8 take the entry level.
- R8: Cycles 13, 15 and 17 are reads at VEC_BASE+4n, +1 and +2. The new PC is {byte2[3:0], byte1, byte0}.
- R9: `busy` is 1 for exactly 20 cycles and `done` is 1 only in the last of them. From the following cycle, `pc_out` holds the vector and `sp_out` holds the start SP minus 4, modulo 2^16.
- R10: `bus_rd` and `bus_wr` are never 1 together. Both are 0 in every cycle that is not one of the listed memory cycles.
- R11: After reset, `busy`, `done`, both strobes, `flg_out`, `pc_out` and `sp_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | A maskable request has won arbitration |
| at_boundary | input | 1 | The current instruction is completing |
| str_active | input | 1 | A suspendable string or repeat instruction is running |
| swi_req | input | 1 | A software interrupt instruction requests entry |
| swi_num | input | 6 | Software interrupt number |
| flg_in | input | 12 | Current flag register, captured at start |
| pc_in | input | 20 | Return address, captured at start |
| sp_in | input | 16 | Interrupt stack pointer, captured at start |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| bus_addr | output | 20 | Memory address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| flg_out | output | 12 | Working flag register |
| pc_out | output | 20 | Working program counter |
| sp_out | output | 16 | Working stack pointer |
| busy | output | 1 | An entry sequence is in progress |
| done | output | 1 | The new program counter is being loaded |
| suspend | output | 1 | Suspend the running string instruction |

## Verification
The bench builds the block with VEC_BASE at 0FD00h. Interrupt numbers 5, 10, 17, 40 and 63 then place the vector reads across the whole 256-byte table, up to its last entry at 0FDFCh to 0FDFEh. A start stack pointer of 2 makes the pushes wrap to FFFEh and FFFFh, and makes the final pointer wrap as well. Held requests test entries that run back to back. A simultaneous software and hardware start tests priority, and software numbers on both sides of 32 test the stack-select exception.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 8;
    localparam int FLG_W      = 12;
    localparam int SP_W       = 16;
    localparam int NUM_W      = 6;
    localparam int LVL_W      = 3;
    localparam int FLG_U      = 7;
    localparam int FLG_I      = 6;
    localparam int FLG_D      = 5;
    localparam int IPL_LSB    = 8;
    localparam int KEEP_U_MIN = 32;
    localparam int HOLD_A_LEN = 3;
    localparam int HOLD_B_LEN = 2;
    localparam int HOLD_CNT_W = $clog2(HOLD_A_LEN);
    localparam int VEC_HI_W   = ADDR_W - 2 * DATA_W;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_ACK_NUM,
        ST_ACK_LVL,
        ST_SAVE,
        ST_HOLD_A,
        ST_PUSH_F0,
        ST_PUSH_F1,
        ST_HOLD_B,
        ST_PUSH_P0,
        ST_PUSH_P1,
        ST_SET_IPL,
        ST_VEC0,
        ST_GAP0,
        ST_VEC1,
        ST_GAP1,
        ST_VEC2,
        ST_GAP2,
        ST_LOAD
    } ent_state_t;
endpackage

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_req,
    input  logic       at_boundary,
    input  logic       str_active,
    input  logic       swi_req,
    output ent_state_t state_q,
    output logic       start,
    output logic       suspend
);
    ent_state_t            state_d;
    logic [HOLD_CNT_W-1:0] cnt_q;
    logic                  idle;

    assign idle = (state_q == ST_IDLE);

    always_comb begin
        start   = idle && (swi_req || (irq_req && (at_boundary || str_active)));
        suspend = idle && !swi_req && irq_req && str_active && !at_boundary;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_ACK_NUM;
            ST_ACK_NUM: state_d = ST_ACK_LVL;
            ST_ACK_LVL: state_d = ST_SAVE;
            ST_SAVE:    state_d = ST_HOLD_A;
            ST_HOLD_A:  if (cnt_q == HOLD_CNT_W'(HOLD_A_LEN - 1)) state_d = ST_PUSH_F0;
            ST_PUSH_F0: state_d = ST_PUSH_F1;
            ST_PUSH_F1: state_d = ST_HOLD_B;
            ST_HOLD_B:  if (cnt_q == HOLD_CNT_W'(HOLD_B_LEN - 1)) state_d = ST_PUSH_P0;
            ST_PUSH_P0: state_d = ST_PUSH_P1;
            ST_PUSH_P1: state_d = ST_SET_IPL;
            ST_SET_IPL: state_d = ST_VEC0;
            ST_VEC0:    state_d = ST_GAP0;
            ST_GAP0:    state_d = ST_VEC1;
            ST_VEC1:    state_d = ST_GAP1;
            ST_GAP1:    state_d = ST_VEC2;
            ST_VEC2:    state_d = ST_GAP2;
            ST_GAP2:    state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ent_state_t        state_q,
    input  logic              start,
    input  logic              swi_req,
    input  logic [NUM_W-1:0]  swi_num,
    input  logic [FLG_W-1:0]  flg_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [FLG_W-1:0]  flg_q,
    output logic [FLG_W-1:0]  tmp_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [SP_W-1:0]   sp_q,
    output logic [NUM_W-1:0]  num_q,
    output logic              soft_q
);
    logic [LVL_W-1:0]  lvl_q;
    logic [ADDR_W-1:0] vec_q;
    logic              keep_u;

    assign keep_u = soft_q && (int'(num_q) >= KEEP_U_MIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q  <= '0;
            tmp_q  <= '0;
            pc_q   <= '0;
            sp_q   <= '0;
            num_q  <= '0;
            lvl_q  <= '0;
            vec_q  <= '0;
            soft_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    flg_q  <= flg_in;
                    pc_q   <= pc_in;
                    sp_q   <= sp_in;
                    soft_q <= swi_req;
                    if (swi_req) begin
                        num_q <= swi_num;
                        lvl_q <= flg_in[IPL_LSB +: LVL_W];
                    end
                end
                ST_ACK_NUM: if (!soft_q) num_q <= bus_rdata[NUM_W-1:0];
                ST_ACK_LVL: if (!soft_q) lvl_q <= bus_rdata[LVL_W-1:0];
                ST_SAVE: begin
                    tmp_q        <= flg_q;
                    flg_q[FLG_I] <= 1'b0;
                    flg_q[FLG_D] <= 1'b0;
                    if (!keep_u) flg_q[FLG_U] <= 1'b0;
                end
                ST_SET_IPL: flg_q[IPL_LSB +: LVL_W] <= lvl_q;
                ST_VEC0: vec_q[DATA_W-1:0]        <= bus_rdata;
                ST_VEC1: vec_q[2*DATA_W-1:DATA_W] <= bus_rdata;
                ST_VEC2: vec_q[ADDR_W-1:2*DATA_W] <= bus_rdata[VEC_HI_W-1:0];
                ST_LOAD: begin
                    pc_q <= vec_q;
                    sp_q <= sp_q - SP_W'(4);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_entry_bus.sv
module irq_entry_bus
    import irq_entry_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE = 20'h0FD00
) (
    input  ent_state_t        state_q,
    input  logic              soft_q,
    input  logic [NUM_W-1:0]  num_q,
    input  logic [FLG_W-1:0]  tmp_q,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [SP_W-1:0]   sp_q,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata
);
    localparam int PAD_W = ADDR_W - SP_W;

    logic [ADDR_W-1:0] vec_addr;

    function automatic logic [ADDR_W-1:0] stk(input logic [SP_W-1:0] sp, input int off);
        logic [SP_W-1:0] a;
        a = sp - SP_W'(off);
        return {{PAD_W{1'b0}}, a};
    endfunction

    assign vec_addr = VEC_BASE + {{(ADDR_W-NUM_W-2){1'b0}}, num_q, 2'b00};

    always_comb begin
        bus_addr  = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        unique case (state_q)
            ST_ACK_NUM, ST_ACK_LVL: bus_rd = !soft_q;
            ST_PUSH_F0: begin
                bus_wr = 1'b1; bus_addr = stk(sp_q, 2); bus_wdata = tmp_q[DATA_W-1:0];
            end
            ST_PUSH_F1: begin
                bus_wr = 1'b1; bus_addr = stk(sp_q, 1);
                bus_wdata = {pc_q[ADDR_W-1:2*DATA_W], tmp_q[FLG_W-1:DATA_W]};
            end
            ST_PUSH_P0: begin
                bus_wr = 1'b1; bus_addr = stk(sp_q, 4); bus_wdata = pc_q[DATA_W-1:0];
            end
            ST_PUSH_P1: begin
                bus_wr = 1'b1; bus_addr = stk(sp_q, 3); bus_wdata = pc_q[2*DATA_W-1:DATA_W];
            end
            ST_VEC0: begin bus_rd = 1'b1; bus_addr = vec_addr; end
            ST_VEC1: begin bus_rd = 1'b1; bus_addr = vec_addr + ADDR_W'(1); end
            ST_VEC2: begin bus_rd = 1'b1; bus_addr = vec_addr + ADDR_W'(2); end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE = 20'h0FD00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              at_boundary,
    input  logic              str_active,
    input  logic              swi_req,
    input  logic [NUM_W-1:0]  swi_num,
    input  logic [FLG_W-1:0]  flg_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [FLG_W-1:0]  flg_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic [SP_W-1:0]   sp_out,
    output logic              busy,
    output logic              done,
    output logic              suspend
);
    ent_state_t       state_q;
    logic             start;
    logic             soft_q;
    logic [NUM_W-1:0] num_q;
    logic [FLG_W-1:0] tmp_q;

    irq_entry_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .at_boundary(at_boundary),
        .str_active(str_active), .swi_req(swi_req), .state_q(state_q),
        .start(start), .suspend(suspend)
    );

    irq_entry_regs u_regs (
        .clk(clk), .rst_n(rst_n), .state_q(state_q), .start(start),
        .swi_req(swi_req), .swi_num(swi_num), .flg_in(flg_in), .pc_in(pc_in),
        .sp_in(sp_in), .bus_rdata(bus_rdata), .flg_q(flg_out), .tmp_q(tmp_q),
        .pc_q(pc_out), .sp_q(sp_out), .num_q(num_q), .soft_q(soft_q)
    );

    irq_entry_bus #(.VEC_BASE(VEC_BASE)) u_bus (
        .state_q(state_q), .soft_q(soft_q), .num_q(num_q), .tmp_q(tmp_q),
        .pc_q(pc_out), .sp_q(sp_out), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata)
    );

    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_LOAD);
    end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_entry_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              at_boundary,
    input logic              str_active,
    input logic              swi_req,
    input logic              busy,
    input logic              done,
    input logic              suspend,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr
);
    logic [4:0] seq_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     seq_cnt <= '0;
        else if (!busy) seq_cnt <= '0;
        else            seq_cnt <= seq_cnt + 5'd1;
    end

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr));
    p_hw_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && at_boundary) |=> busy);
    p_suspend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |-> (!busy && !swi_req && irq_req && str_active && !at_boundary));
    p_sw_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && swi_req) |=> busy);
    p_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seq_cnt == 5'd19));
    p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_ack_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && seq_cnt < 5'd2) |-> (bus_addr == '0));
    p_stack_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr[ADDR_W-1:SP_W] == '0));
endmodule

bind irq_entry_seq irq_entry_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .at_boundary(at_boundary),
    .str_active(str_active), .swi_req(swi_req), .busy(busy), .done(done),
    .suspend(suspend), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
    localparam logic [19:0] VB = 20'h0FD00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0, at_boundary = 1'b0, str_active = 1'b0, swi_req = 1'b0;
    logic [5:0]  swi_num = '0;
    logic [11:0] flg_in = '0;
    logic [19:0] pc_in = '0;
    logic [15:0] sp_in = '0;
    logic [7:0]  bus_rdata;
    logic [19:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata;
    logic [11:0] flg_out;
    logic [19:0] pc_out;
    logic [15:0] sp_out;
    logic        busy, done, suspend;

    logic [5:0]  hw_num = '0;
    logic [2:0]  hw_lvl = '0;

    int n_chk = 0, n_fail = 0;
    logic cmp_en = 1'b0;

    irq_entry_seq #(.VEC_BASE(VB)) u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .at_boundary(at_boundary),
        .str_active(str_active), .swi_req(swi_req), .swi_num(swi_num),
        .flg_in(flg_in), .pc_in(pc_in), .sp_in(sp_in), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .flg_out(flg_out), .pc_out(pc_out), .sp_out(sp_out),
        .busy(busy), .done(done), .suspend(suspend)
    );

    always #10 clk = ~clk;

    // Reference model state
    int          m_cyc;
    logic [11:0] m_flg, m_tmp;
    logic [19:0] m_pc, m_vec;
    logic [15:0] m_sp;
    logic        m_soft;
    logic [5:0]  m_num;
    logic [2:0]  m_lvl;

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h3C;
    endfunction

    function automatic logic [19:0] vec_a(input logic [5:0] n, input int k);
        return VB + {12'h0, n, 2'b00} + 20'(k);
    endfunction

    function automatic logic [19:0] stk_a(input logic [15:0] sp, input int off);
        logic [15:0] s;
        s = sp - 16'(off);
        return {4'h0, s};
    endfunction

    always_comb begin
        if (bus_addr == 20'h0)
            bus_rdata = (m_cyc == 0) ? {2'b10, hw_num} : {5'b10101, hw_lvl};
        else
            bus_rdata = mem_byte(bus_addr);
    end

    always @(posedge clk) begin
        logic [7:0] hb;
        if (!rst_n) begin
            m_cyc <= -1; m_flg <= '0; m_tmp <= '0; m_pc <= '0; m_vec <= '0;
            m_sp <= '0; m_soft <= 1'b0; m_num <= '0; m_lvl <= '0;
        end else if (m_cyc < 0) begin
            if (swi_req || (irq_req && (at_boundary || str_active))) begin
                m_cyc <= 0; m_flg <= flg_in; m_pc <= pc_in; m_sp <= sp_in;
                m_soft <= swi_req;
                if (swi_req) begin m_num <= swi_num; m_lvl <= flg_in[10:8]; end
            end
        end else begin
            m_cyc <= (m_cyc == 19) ? -1 : m_cyc + 1;
            case (m_cyc)
                0: if (!m_soft) m_num <= hw_num;
                1: if (!m_soft) m_lvl <= hw_lvl;
                2: begin
                    m_tmp <= m_flg;
                    m_flg[6] <= 1'b0;
                    m_flg[5] <= 1'b0;
                    if (!(m_soft && m_num >= 6'd32)) m_flg[7] <= 1'b0;
                end
                12: m_flg[10:8] <= m_lvl;
                13: m_vec[7:0] <= mem_byte(vec_a(m_num, 0));
                15: m_vec[15:8] <= mem_byte(vec_a(m_num, 1));
                17: begin hb = mem_byte(vec_a(m_num, 2)); m_vec[19:16] <= hb[3:0]; end
                19: begin m_pc <= m_vec; m_sp <= m_sp - 16'd4; end
                default: ;
            endcase
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic e_rd, e_wr, e_su;
        logic [19:0] e_addr;
        logic [7:0]  e_wd;
        string ra, rs, rf;
        if (cmp_en) begin
            e_rd = ((m_cyc == 0 || m_cyc == 1) && !m_soft) || m_cyc == 13 || m_cyc == 15 || m_cyc == 17;
            e_wr = (m_cyc == 6 || m_cyc == 7 || m_cyc == 10 || m_cyc == 11);
            e_su = (m_cyc < 0) && !swi_req && irq_req && str_active && !at_boundary;
            e_addr = 20'h0; e_wd = 8'h0;
            case (m_cyc)
                6:  begin e_addr = stk_a(m_sp, 2); e_wd = m_tmp[7:0]; end
                7:  begin e_addr = stk_a(m_sp, 1); e_wd = {m_pc[19:16], m_tmp[11:8]}; end
                10: begin e_addr = stk_a(m_sp, 4); e_wd = m_pc[7:0]; end
                11: begin e_addr = stk_a(m_sp, 3); e_wd = m_pc[15:8]; end
                13: e_addr = vec_a(m_num, 0);
                15: e_addr = vec_a(m_num, 1);
                17: e_addr = vec_a(m_num, 2);
                default: ;
            endcase
            ra = (m_cyc < 2) ? "R2" : ((m_cyc <= 11) ? "R6" : "R8");
            rs = ((m_cyc == 0 || m_cyc == 1) && m_soft) ? "R3" : "R10";
            rf = (m_soft && m_num >= 6'd32) ? "R5" : "R4";
            if (!rst_n) begin ra = "R11"; rs = "R11"; rf = "R11"; end
            chk(rst_n ? "R9" : "R11", "busy", 32'(busy), 32'(m_cyc >= 0));
            chk(rst_n ? "R9" : "R11", "done", 32'(done), 32'(m_cyc == 19));
            chk(rs, "bus_rd", 32'(bus_rd), 32'(e_rd));
            chk(rs, "bus_wr", 32'(bus_wr), 32'(e_wr));
            if (e_rd || e_wr) chk(ra, "bus_addr", 32'(bus_addr), 32'(e_addr));
            if (e_wr) chk("R6", "bus_wdata", 32'(bus_wdata), 32'(e_wd));
            chk(rf, "flags[7:0]", 32'(flg_out[7:0]), 32'(m_flg[7:0]));
            chk(rst_n ? "R7" : "R11", "flags[11:8]", 32'(flg_out[11:8]), 32'(m_flg[11:8]));
            chk(rst_n ? "R8" : "R11", "pc_out", 32'(pc_out), 32'(m_pc));
            chk(rst_n ? "R9" : "R11", "sp_out", 32'(sp_out), 32'(m_sp));
            chk("R1", "suspend", 32'(suspend), 32'(e_su));
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1; cmp_en = 1'b1;   // R11 reset state compared from here
        step(2);
        rst_n = 1'b1;
        step(2);
        // R1/R2: hardware entry at an instruction boundary
        flg_in = 12'h3E5; pc_in = 20'hABCDE; sp_in = 16'h0800; hw_num = 6'd5; hw_lvl = 3'd3;
        irq_req = 1'b1; at_boundary = 1'b1;
        step(1);
        irq_req = 1'b0; at_boundary = 1'b0;
        step(24);
        // R1: pending request waits without boundary, then suspends a string op; stack wrap
        flg_in = 12'h0FF; pc_in = 20'h12345; sp_in = 16'h0002; hw_num = 6'd63; hw_lvl = 3'd6;
        irq_req = 1'b1;
        step(5);
        str_active = 1'b1;
        step(1);
        str_active = 1'b0; irq_req = 1'b0;
        step(24);
        // R5: software entry number 40 keeps the stack-select flag
        flg_in = 12'h5A0; pc_in = 20'hF0F0F; sp_in = 16'h1000; swi_num = 6'd40; swi_req = 1'b1;
        step(1);
        swi_req = 1'b0;
        step(24);
        // R3/R4: software entry number 10 beats a simultaneous hardware request
        flg_in = 12'h2E0; pc_in = 20'h00777; sp_in = 16'h0400; swi_num = 6'd10; hw_num = 6'd1;
        swi_req = 1'b1; irq_req = 1'b1; at_boundary = 1'b1;
        step(1);
        swi_req = 1'b0; irq_req = 1'b0; at_boundary = 1'b0;
        step(24);
        // R9: held request gives back-to-back entries
        flg_in = 12'h7C0; pc_in = 20'h54321; sp_in = 16'hFFF0; hw_num = 6'd17; hw_lvl = 3'd7;
        irq_req = 1'b1; at_boundary = 1'b1;
        step(45);
        irq_req = 1'b0; at_boundary = 1'b0;
        step(24);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule